// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives a two-channel stream on a serial audio port as a clock slave. It runs entirely on the incoming bit clock. On each rising edge it samples the frame sync and the serial data line. It then rebuilds a left word and a right word and pulses a valid strobe once a whole frame has arrived. Four framings are supported: I2S, left-justified, right-justified, and a time-division (TDM/DSP) framing in which a rising sync marks the frame start and the two channels occupy the first two slots.

Software-owned configuration pins set up the capture. They select the framing, the word length (16, 20, 24 or 32 bits), a 9-bit data offset counted in bit-clock cycles, and a short-sync mode for TDM frame syncs that may be only one bit clock wide. Samples arrive as two's complement, MSB first. Words shorter than the output width are left-aligned and their low bits are zero-filled. Configuration must be held steady while frames are flowing, and is normally changed only during reset.

Timing is stated relative to edge E0. E0 is the first bit-clock rising edge that samples a new sync level (for TDM, the first one that samples the sync high). E1 is the edge after it, and so on.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `left_o` and `right_o` are all zeros and `valid_o` is low.
- R2: `cfg_fmt_i` selects the framing: 00 is I2S, 01 is left-justified, 10 is right-justified and 11 is TDM. In I2S the left channel is sent while the sync is low and the right channel while it is high. The MSB of each channel is sampled on edge E(1+offset) after the sync transition.
- R3: `cfg_wlen_i` selects the word length: 00 is 16 bits, 01 is 20, 10 is 24 and 11 is 32. A captured word is left-aligned in its output with all lower bits zero.
- R4: In left-justified framing the left channel is sent while the sync is high. The MSB of each channel is sampled on edge E(offset).
- R5: In right-justified framing the left channel is sent while the sync is high. The LSB of each channel is the bit sampled on the last edge before the next sync transition, and the offset has no effect.
- R6: In TDM framing a rising sync starts a frame. Slot 0 (left) has its MSB on edge E(1+offset), and slot 1 (right) follows directly after the last bit of slot 0.
- R7: With `cfg_sync_i` = 01 in TDM, a sync that is high on only one edge starts a frame. The sync level after that edge is never used.
- R8: With `cfg_sync_i` not 01 in TDM, a frame starts only when the sync is seen high on two edges in a row. A sync high for a single edge is ignored: no strobe occurs and the outputs do not change.
- R9: The offset covers the full range 0 to 511 and delays data capture by that many bit clocks in I2S, left-justified and TDM framing.
- R10: `valid_o` goes high for exactly one bit clock, on the edge that stores the right word. It does so only if a left word has been stored since the previous strobe. Both outputs hold the frame's words while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sck | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync / channel select line |
| sdata_i | input | 1 | Serial audio data, MSB first |
| cfg_fmt_i | input | 2 | Framing select |
| cfg_sync_i | input | 2 | TDM short-sync select (01 = one-clock sync accepted) |
| cfg_wlen_i | input | 2 | Word-length select |
| cfg_offset_i | input | OFFSET_W (9) | Data offset in bit clocks |
| left_o | output | DATA_W (32) | Last left word, left-aligned |
| right_o | output | DATA_W (32) | Last right word, left-aligned |
| valid_o | output | 1 | One-clock strobe when a full frame is held |

## Verification
In right-justified framing, two things happen on the same edge: the right word of one frame is stored and the strobe is raised, while the sync has just risen to begin the next frame's left channel. The bench provokes this by sending right-justified frames back to back with no gap. It judges the result by checking that every strobe carries the words of the finished frame, and that the next left word still arrives intact on its own strobe. In TDM with the normal sync setting, the two-edge start filter and the data capture both act on the edge after the sync rises. Frames with one-edge syncs are sent first and must produce nothing; a later frame with a two-edge sync must still be captured at the same data position.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
package asr_pkg;
   typedef enum logic [1:0] {
      FMT_I2S = 2'b00,
      FMT_LJ  = 2'b01,
      FMT_RJ  = 2'b10,
      FMT_TDM = 2'b11
   } asr_fmt_e;

   localparam logic [1:0]  SHORT_SYNC_ON = 2'b01;
   localparam int unsigned WORD_MAX      = 32;

   function automatic logic [5:0] wlen_bits(input logic [1:0] code);
      case (code)
         2'b00:   return 6'd16;
         2'b01:   return 6'd20;
         2'b10:   return 6'd24;
         default: return 6'd32;
      endcase
   endfunction
endpackage

// File: rtl/asr_frame_detect.sv
`timescale 1ns/1ps
module asr_frame_detect
   import asr_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       fsync_i,
   input  asr_fmt_e   fmt_i,
   input  logic [1:0] short_sync_i,
   output logic       start_o,
   output logic       start_late_o,
   output logic       level_prev_o
);
   logic fs_q, fs_qq;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fs_q  <= 1'b0;
         fs_qq <= 1'b0;
      end else begin
         fs_q  <= fsync_i;
         fs_qq <= fs_q;
      end
   end

   // Half formats restart on any level change; TDM on a rise, filtered
   // over two edges unless the short-sync mode is selected.
   always_comb begin
      start_o      = 1'b0;
      start_late_o = 1'b0;
      if (fmt_i != FMT_TDM) begin
         start_o = fsync_i ^ fs_q;
      end else if (short_sync_i == SHORT_SYNC_ON) begin
         start_o = fsync_i & ~fs_q;
      end else begin
         start_o      = fsync_i & fs_q & ~fs_qq;
         start_late_o = start_o;
      end
   end

   assign level_prev_o = fs_q;
endmodule

// File: rtl/asr_bit_counter.sv
`timescale 1ns/1ps
module asr_bit_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             start_late_i,
   output logic [CNT_W-1:0] idx_o
);
   localparam logic [CNT_W-1:0] CNT_SAT = '1;

   logic [CNT_W-1:0] cnt_q;

   assign idx_o = start_i ? CNT_W'(start_late_i) : cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= CNT_SAT;
      end else if (start_i || (cnt_q != CNT_SAT)) begin
         cnt_q <= idx_o + 1'b1;
      end
   end
endmodule

// File: rtl/asr_shift_hist.sv
`timescale 1ns/1ps
module asr_shift_hist #(
   parameter int HIST_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sdata_i,
   output logic [HIST_W-1:0] hist_o,
   output logic [HIST_W-1:0] hist_next_o
);
   logic [HIST_W-1:0] hist_q;

   assign hist_next_o = {hist_q[HIST_W-2:0], sdata_i};
   assign hist_o      = hist_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= hist_next_o;
   end
endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
   import asr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int OFFSET_W = 9
) (
   input  logic                clk_sck,
   input  logic                rst_n,
   input  logic                fsync_i,
   input  logic                sdata_i,
   input  logic [1:0]          cfg_fmt_i,
   input  logic [1:0]          cfg_sync_i,
   input  logic [1:0]          cfg_wlen_i,
   input  logic [OFFSET_W-1:0] cfg_offset_i,
   output logic [DATA_W-1:0]   left_o,
   output logic [DATA_W-1:0]   right_o,
   output logic                valid_o
);
   localparam int CNT_W = $clog2((2 ** OFFSET_W) + 2 * WORD_MAX + 4);

   if (DATA_W < WORD_MAX) begin : g_bad_data_w
      $error("audio_serial_rx: DATA_W must be at least 32");
   end
   if (OFFSET_W < 1 || OFFSET_W > 12) begin : g_bad_offset_w
      $error("audio_serial_rx: OFFSET_W out of range 1..12");
   end

   asr_fmt_e fmt;
   assign fmt = asr_fmt_e'(cfg_fmt_i);

   logic start, start_late, level_prev;
   logic [CNT_W-1:0] idx;
   logic [WORD_MAX-1:0] hist, hist_next;

   asr_frame_detect i_detect (
      .clk_i        (clk_sck),
      .rst_ni       (rst_n),
      .fsync_i      (fsync_i),
      .fmt_i        (fmt),
      .short_sync_i (cfg_sync_i),
      .start_o      (start),
      .start_late_o (start_late),
      .level_prev_o (level_prev)
   );

   asr_bit_counter #(.CNT_W(CNT_W)) i_counter (
      .clk_i        (clk_sck),
      .rst_ni       (rst_n),
      .start_i      (start),
      .start_late_i (start_late),
      .idx_o        (idx)
   );

   asr_shift_hist #(.HIST_W(WORD_MAX)) i_hist (
      .clk_i       (clk_sck),
      .rst_ni      (rst_n),
      .sdata_i     (sdata_i),
      .hist_o      (hist),
      .hist_next_o (hist_next)
   );

   // Capture positions relative to the frame/half start edge.
   logic [5:0]       wbits;
   logic [CNT_W-1:0] first_pos, pos_a, pos_b;
   assign wbits     = wlen_bits(cfg_wlen_i);
   assign first_pos = CNT_W'(cfg_offset_i) + CNT_W'(fmt != FMT_LJ);
   assign pos_a     = first_pos + CNT_W'(wbits) - 1'b1;
   assign pos_b     = pos_a + CNT_W'(wbits);

   logic half_left_q, half_left;
   assign half_left = start ? ((fmt == FMT_I2S) ? ~fsync_i : fsync_i) : half_left_q;

   logic                cap_left, cap_right;
   logic [WORD_MAX-1:0] cap_src, cap_aligned;
   logic [DATA_W-1:0]   cap_word;

   always_comb begin
      cap_left  = 1'b0;
      cap_right = 1'b0;
      cap_src   = hist_next;
      case (fmt)
         FMT_RJ: begin
            cap_src   = hist;
            cap_left  = start & level_prev;
            cap_right = start & ~level_prev;
         end
         FMT_TDM: begin
            cap_left  = (idx == pos_a);
            cap_right = (idx == pos_b);
         end
         default: begin
            cap_left  = (idx == pos_a) & half_left;
            cap_right = (idx == pos_a) & ~half_left;
         end
      endcase
   end

   assign cap_aligned = cap_src << (6'd32 - wbits);

   if (DATA_W == WORD_MAX) begin : g_pad_none
      assign cap_word = cap_aligned;
   end else begin : g_pad_low
      assign cap_word = {cap_aligned, {(DATA_W - WORD_MAX){1'b0}}};
   end

   logic left_seen_q;

   always_ff @(posedge clk_sck or negedge rst_n) begin
      if (!rst_n) begin
         half_left_q <= 1'b0;
         left_seen_q <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         if (start) half_left_q <= half_left;
         if (cap_left) begin
            left_o      <= cap_word;
            left_seen_q <= 1'b1;
         end else if (cap_right) begin
            left_seen_q <= 1'b0;
         end
         if (cap_right) right_o <= cap_word;
         valid_o <= cap_right & left_seen_q;
      end
   end
endmodule

// File: rtl/audio_serial_rx_chk.sv
`timescale 1ns/1ps
module audio_serial_rx_chk
   import asr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk_sck,
   input logic              rst_n,
   input logic              fsync_i,
   input logic [1:0]        cfg_fmt_i,
   input logic [1:0]        cfg_wlen_i,
   input logic [DATA_W-1:0] left_o,
   input logic [DATA_W-1:0] right_o,
   input logic              valid_o
);
   logic [DATA_W-1:0] keep_mask;
   assign keep_mask = {DATA_W{1'b1}} << (DATA_W - int'(wlen_bits(cfg_wlen_i)));

   a_r10_valid_single: assert property (@(posedge clk_sck) disable iff (!rst_n)
      valid_o |=> !valid_o);

   a_r3_zero_fill: assert property (@(posedge clk_sck) disable iff (!rst_n)
      valid_o |-> (((left_o & ~keep_mask) == '0) && ((right_o & ~keep_mask) == '0)));

   a_r2_i2s_right_high: assert property (@(posedge clk_sck) disable iff (!rst_n)
      (valid_o && cfg_fmt_i == FMT_I2S) |-> $past(fsync_i));

   a_r4_lj_right_low: assert property (@(posedge clk_sck) disable iff (!rst_n)
      (valid_o && cfg_fmt_i == FMT_LJ) |-> !$past(fsync_i));

   a_r5_rj_on_rise: assert property (@(posedge clk_sck) disable iff (!rst_n)
      (valid_o && cfg_fmt_i == FMT_RJ) |-> ($past(fsync_i) && !$past(fsync_i, 2)));
endmodule

bind audio_serial_rx audio_serial_rx_chk #(.DATA_W(DATA_W)) i_chk (
   .clk_sck    (clk_sck),
   .rst_n      (rst_n),
   .fsync_i    (fsync_i),
   .cfg_fmt_i  (cfg_fmt_i),
   .cfg_wlen_i (cfg_wlen_i),
   .left_o     (left_o),
   .right_o    (right_o),
   .valid_o    (valid_o)
);

// File: tb/test_audio_serial_rx.sv
`timescale 1ns/1ps
module test_audio_serial_rx;
   localparam int DW = 32;
   localparam int OW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fsync = 1'b0;
   logic          sdata = 1'b0;
   logic [1:0]    cfg_fmt = 2'b00;
   logic [1:0]    cfg_sync = 2'b00;
   logic [1:0]    cfg_wlen = 2'b10;
   logic [OW-1:0] cfg_offset = '0;
   logic [DW-1:0] left_o, right_o;
   logic          valid_o;

   always #2.5 clk = ~clk;

   audio_serial_rx #(.DATA_W(DW), .OFFSET_W(OW)) i_audio_serial_rx (
      .clk_sck      (clk),
      .rst_n        (rst_n),
      .fsync_i      (fsync),
      .sdata_i      (sdata),
      .cfg_fmt_i    (cfg_fmt),
      .cfg_sync_i   (cfg_sync),
      .cfg_wlen_i   (cfg_wlen),
      .cfg_offset_i (cfg_offset),
      .left_o       (left_o),
      .right_o      (right_o),
      .valid_o      (valid_o)
   );

   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;
   string       cur_req = "R1";
   logic [63:0] exp_q[$];
   logic [63:0] mon_exp;
   int          seed = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int wl(input logic [1:0] c);
      case (c)
         2'b00:   return 16;
         2'b01:   return 20;
         2'b10:   return 24;
         default: return 32;
      endcase
   endfunction

   function automatic logic [31:0] amask(input int w);
      return 32'hFFFF_FFFF << (32 - w);
   endfunction

   function automatic logic [31:0] next_val();
      seed++;
      return (32'h9E37_79B9 * seed) ^ 32'h5A5A_C3C3;
   endfunction

   // Scoreboard monitor: every strobe must match the oldest expected frame.
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, cur_req, "unexpected strobe", {left_o, right_o}, 64'd0);
         end else begin
            mon_exp = exp_q.pop_front();
            check({left_o, right_o} == mon_exp, cur_req, "frame words",
                  {left_o, right_o}, mon_exp);
         end
      end
   end

   task automatic drive(input logic fs, input logic d);
      @(negedge clk);
      fsync = fs;
      sdata = d;
   endtask

   task automatic start_group(input logic [1:0] fmt, input logic [1:0] sync,
                              input logic [1:0] wlen, input int off,
                              input logic idle, input string req);
      rst_n      = 1'b0;
      cfg_fmt    = fmt;
      cfg_sync   = sync;
      cfg_wlen   = wlen;
      cfg_offset = OW'(off);
      fsync      = idle;
      sdata      = 1'b0;
      repeat (3) @(negedge clk);
      cur_req    = req;
      rst_n      = 1'b1;
   endtask

   // k counts edges from E0 of this half.
   task automatic send_half(input logic lvl, input int w, input int n,
                            input int h, input logic [31:0] word);
      for (int k = 0; k < h; k++) begin
         int   p;
         logic b;
         if (cfg_fmt == 2'b10)      p = k - (h - w);
         else if (cfg_fmt == 2'b01) p = k - n;
         else                       p = k - n - 1;
         b = (p >= 0 && p < w) ? word[31 - p] : 1'b0;
         drive(lvl, b);
      end
   endtask

   task automatic send_lr(input int h, input logic [31:0] l, input logic [31:0] r);
      int   w;
      int   n;
      logic lvl_left;
      w = wl(cfg_wlen);
      n = int'(cfg_offset);
      lvl_left = (cfg_fmt == 2'b00) ? 1'b0 : 1'b1;
      exp_q.push_back({l & amask(w), r & amask(w)});
      send_half(lvl_left, w, n, h, l);
      send_half(~lvl_left, w, n, h, r);
   endtask

   task automatic send_tdm(input int fsw, input logic [31:0] l,
                           input logic [31:0] r, input bit expect_it);
      int w;
      int n;
      int f;
      w = wl(cfg_wlen);
      n = int'(cfg_offset);
      f = n + 2 * w + 4;
      if (expect_it) exp_q.push_back({l & amask(w), r & amask(w)});
      for (int k = 0; k < f; k++) begin
         int   p;
         logic b;
         p = k - n - 1;
         if (p >= 0 && p < w)          b = l[31 - p];
         else if (p >= w && p < 2 * w) b = r[31 - (p - w)];
         else                          b = 1'b0;
         drive(k < fsw, b);
      end
   endtask

   task automatic finish_group(input int h, input string req);
      if (cfg_fmt == 2'b11) begin
         for (int k = 0; k < 6; k++) drive(1'b0, 1'b0);
      end else begin
         send_half((cfg_fmt == 2'b00) ? 1'b0 : 1'b1, wl(cfg_wlen), 0, h, 32'd0);
      end
      check(exp_q.size() == 0, req, "all frames strobed", 64'(exp_q.size()), 64'd0);
      exp_q.delete();
   endtask

   task automatic run_lr(input logic [1:0] fmt, input logic [1:0] wlen,
                         input int off, input int h, input int frames,
                         input string req);
      logic idle;
      idle = (fmt == 2'b00) ? 1'b1 : 1'b0;
      start_group(fmt, 2'b00, wlen, off, idle, req);
      send_half(idle, wl(wlen), off, h, 32'd0);
      for (int i = 0; i < frames; i++) send_lr(h, next_val(), next_val());
      finish_group(h, req);
   endtask

   task automatic run_tdm(input logic [1:0] sync, input logic [1:0] wlen,
                          input int off, input int fsw, input int frames,
                          input string req);
      start_group(2'b11, sync, wlen, off, 1'b0, req);
      for (int k = 0; k < 4; k++) drive(1'b0, 1'b0);
      for (int i = 0; i < frames; i++) send_tdm(fsw, next_val(), next_val(), 1'b1);
      finish_group(0, req);
   endtask

   initial begin
      // R1: reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check({left_o, right_o} == 64'd0 && !valid_o, "R1", "in reset",
            {left_o, right_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check({left_o, right_o} == 64'd0 && !valid_o, "R1", "after release",
            {left_o, right_o}, 64'd0);

      // R2/R3: I2S, 24-bit and 16-bit with an offset
      run_lr(2'b00, 2'b10, 0, 32, 3, "R2_R3_i2s24");
      run_lr(2'b00, 2'b00, 3, 32, 2, "R2_R9_i2s16_off3");
      run_lr(2'b00, 2'b11, 0, 40, 2, "R2_R3_i2s32");
      // R4: left-justified, 20-bit and 32-bit filling the half
      run_lr(2'b01, 2'b01, 0, 32, 3, "R4_R3_lj20");
      run_lr(2'b01, 2'b11, 0, 32, 2, "R4_lj32");
      // R5: right-justified, back-to-back frames, offset must be ignored
      run_lr(2'b10, 2'b10, 0, 32, 3, "R5_rj24");
      run_lr(2'b10, 2'b11, 5, 32, 2, "R5_rj32_off_ignored");
      // R6: TDM with a long sync
      run_tdm(2'b00, 2'b10, 0, 8, 3, "R6_tdm24");
      // R7: one-clock sync in short-sync mode, offset 1
      run_tdm(2'b01, 2'b11, 1, 1, 3, "R7_tdm32_short");
      // R9: largest offset
      run_tdm(2'b01, 2'b00, 511, 1, 2, "R9_tdm16_off511");

      // R8: one-clock syncs ignored in normal sync mode
      start_group(2'b11, 2'b00, 2'b10, 0, 1'b0, "R8_ignore_short");
      for (int k = 0; k < 4; k++) drive(1'b0, 1'b0);
      send_tdm(1, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
      send_tdm(1, 32'hCAFE_F00D, 32'h8765_4321, 1'b0);
      check({left_o, right_o} == 64'd0, "R8", "outputs untouched",
            {left_o, right_o}, 64'd0);
      send_tdm(2, next_val(), next_val(), 1'b1);
      finish_group(0, "R8_R10_two_edge_sync");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule